// File: doc/BRIEF.md
# Three-Channel Compare Timer

This block is an up-counting timer with three compare channels. It is controlled through a small synchronous register bus. The counter advances on qualified ticks. One of five tick-enable inputs supplies the ticks, chosen by a source code. The chosen ticks pass through a programmable main prescaler. The crystal input can also pass through a second, small prescaler placed ahead of the main one. All tick inputs are single-cycle enables in the one clock domain of the block.

Each compare channel raises a status flag when the counter matches its value, and a wrap of the counter raises a rollover flag. Software clears the flags by writing ones to them. Software chooses how the counter behaves after a channel-1 match: it returns to zero (restart), or it keeps counting (free-running). A single interrupt line combines the flags with their enable bits. Three further options are available:
- a self-clearing software reset;
- a mode that zeroes the counter and prescalers when counting is switched on;
- a choice of whether counting goes on while the low-power request is high.

Bus map (word address): 0 control, 1 prescalers, 2 status, 3 interrupt enable, 4 counter (read-only), 5/6/7 compare value of channels 1/2/3. Reads are combinational from `bus_addr`. Writes take effect at the clock edge where `bus_sel` and `bus_wr` are high.

Top module: `cmp_timer`

## Requirements
- R1: After `rst_n` is low at a clock edge, every register reads 0 and `irq` is low. Control bits: [0] run, [1] zero-on-start, [2] count-in-low-power, [3] free-running, [6:4] source code, [7] crystal divider enable, [15] software reset.
- R2: The prescaler register bits [11:0] hold the main divide ratio minus one. The counter advances once per (field+1) selected source ticks, over ratios 1 to 4096.
- R3: With source code 5 and control bit 7 set, the crystal ticks are first divided by (prescaler bits [19:16] + 1). With bit 7 clear, the crystal ticks reach the main prescaler undivided.
- R4: Source codes are 1 peripheral, 2 fast reference, 3 external, 4 slow reference, 5 crystal (`src_ticks` bits 0..4). Codes 0, 6 and 7 produce no counting.
- R5: In free-running mode the counter passes through every match and wraps from all ones to zero. The wrap sets status bit 3.
- R6: In restart mode (control bit 3 = 0), a tick that finds the counter equal to compare channel 1 loads zero instead of incrementing.
- R7: A tick that finds the counter equal to compare channel n sets status bit n-1 (n = 1..3).
- R8: Writing 1 to a status bit clears it, and writing 0x3F clears all flags. A set and a clear of the same bit in the same cycle leave it set.
- R9: `irq` is high exactly when some status bit is set together with the same bit of the interrupt-enable register (address 3).
- R10: Writing control bit 15 makes bit 15 read 1 for SRST_CYCLES cycles. During those cycles all registers and the counter return to defaults, and bus writes are ignored. Afterwards bit 15 reads 0.
- R11: When zero-on-start is set in a control write that takes run from 0 to 1, the counter and both prescalers are zeroed. Without zero-on-start the count is kept across a stop and a restart.
- R12: While `lowpwr` is high and control bit 2 is 0, no counting occurs. With bit 2 set, counting continues.
- R13: While run is 0 the counter holds its value whatever the tick inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | Write strobe (with bus_sel) |
| bus_addr | input | 3 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| src_ticks | input | 5 | Tick enables: peripheral, fast ref, external, slow ref, crystal |
| lowpwr | input | 1 | Low-power request |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the timer with an 8-bit counter (CNT_W = 8) and the default prescaler widths, three channels and a two-cycle software reset. The narrow counter brings the wrap from 255 to 0 and the rollover flag within a few hundred ticks. It also keeps compare values small enough to exercise a match, a restart cycle and the same-cycle set-versus-clear race with exact cycle placement. The full 12-bit and 4-bit prescaler fields stay in place, so the largest main ratio (4096) and the cascaded crystal division are tested at their real widths.

// File: rtl/cmp_timer_pkg.sv
// Shared constants for the compare timer: bus word addresses, field positions
// and the control register layout. Assumes a 32-bit bus and word addressing.
package cmp_timer_pkg;

    localparam int BUS_W     = 32;
    localparam int ADDR_W    = 3;

    localparam int A_CTRL    = 0;
    localparam int A_PRE     = 1;
    localparam int A_STAT    = 2;
    localparam int A_IEN     = 3;
    localparam int A_CNT     = 4;
    localparam int A_CMP0    = 5;

    localparam int XPRE_LSB  = 16;  // crystal prescaler field position
    localparam int SRST_BIT  = 15;  // software reset bit in control

    localparam logic [2:0] SRC_NONE   = 3'd0;
    localparam logic [2:0] SRC_PERIPH = 3'd1;
    localparam logic [2:0] SRC_HFREF  = 3'd2;
    localparam logic [2:0] SRC_EXT    = 3'd3;
    localparam logic [2:0] SRC_LFREF  = 3'd4;
    localparam logic [2:0] SRC_XTAL   = 3'd5;

    // Control bits [7:0], MSB first.
    typedef struct packed {
        logic       xdiv_en;
        logic [2:0] src;
        logic       free_run;
        logic       sleep_count;
        logic       fresh;
        logic       run;
    } ctrl_t;

endpackage

// File: rtl/cmp_timer_div.sv
// Tick divider: passes one of every (ratio_m1+1) input ticks while enabled.
// Assumes tick_in is a one-cycle enable; a smaller new ratio takes effect at
// once because the terminal test is "greater or equal".
module cmp_timer_div #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         en,
    input  logic         tick_in,
    input  logic [W-1:0] ratio_m1,
    output logic         tick_out
);

    logic [W-1:0] acc;
    logic         at_end;

    assign at_end   = (acc >= ratio_m1);
    assign tick_out = en & tick_in & at_end;

    // Advance the phase accumulator on each enabled input tick.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            acc <= '0;
        end else if (en && tick_in) begin
            acc <= at_end ? '0 : acc + 1'b1;
        end
    end

    // R2: every emitted tick starts a new division period.
    a_r2_phase_restart: assert property (@(posedge clk) disable iff (!rst_n)
        tick_out |=> (acc == '0));

endmodule

// File: rtl/cmp_timer_src.sv
// Clock-source selection: picks one tick-enable input by source code and
// optionally divides the crystal ticks by a small prescaler. Reserved and
// zero codes yield no ticks.
module cmp_timer_src #(
    parameter int XPRE_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              en,
    input  logic [2:0]        src,
    input  logic              xdiv_en,
    input  logic [XPRE_W-1:0] xratio_m1,
    input  logic [4:0]        ticks,
    output logic              tick_sel
);
    import cmp_timer_pkg::*;

    logic xdiv_on;
    logic xtick;

    assign xdiv_on = en & (src == SRC_XTAL) & xdiv_en;

    cmp_timer_div #(.W(XPRE_W)) i_xdiv (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (clr),
        .en       (xdiv_on),
        .tick_in  (ticks[4]),
        .ratio_m1 (xratio_m1),
        .tick_out (xtick)
    );

    // Route the selected source onto the common tick line.
    always_comb begin
        case (src)
            SRC_PERIPH: tick_sel = ticks[0];
            SRC_HFREF:  tick_sel = ticks[1];
            SRC_EXT:    tick_sel = ticks[2];
            SRC_LFREF:  tick_sel = ticks[3];
            SRC_XTAL:   tick_sel = xdiv_en ? xtick : ticks[4];
            default:    tick_sel = 1'b0;
        endcase
    end

    // R4: codes 0, 6 and 7 never deliver a tick.
    a_r4_silent_codes: assert property (@(posedge clk) disable iff (!rst_n)
        (src == SRC_NONE || src == 3'd6 || src == 3'd7) |-> !tick_sel);

endmodule

// File: rtl/cmp_timer_count.sv
// Counter with compare channels. On each step it either increments or, in
// restart mode on a channel-1 match, loads zero. Reports per-channel match
// pulses and a wrap pulse. Assumes step is already qualified by enable.
module cmp_timer_count #(
    parameter int CNT_W = 32,
    parameter int NCMP  = 3
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       clr,
    input  logic                       step,
    input  logic                       free_run,
    input  logic [NCMP-1:0][CNT_W-1:0] cmp,
    output logic [CNT_W-1:0]           count,
    output logic [NCMP-1:0]            hit,
    output logic                       wrap
);

    for (genvar i = 0; i < NCMP; i++) begin : g_hit
        assign hit[i] = step & (count == cmp[i]);
    end

    assign wrap = step & (&count);

    // Advance, restart or clear the count.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            count <= '0;
        end else if (step) begin
            count <= (!free_run && hit[0]) ? '0 : count + 1'b1;
        end
    end

    // R13: without a step the count does not move.
    a_r13_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!step && !clr) |=> (count == $past(count)));

    // R6: restart mode returns to zero after a channel-1 match.
    a_r6_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !clr && !free_run && (count == cmp[0])) |=> (count == '0));

    // R5: free-running mode wraps from all ones to zero.
    a_r5_wrap_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !clr && free_run && (&count)) |=> (count == '0));

endmodule

// File: rtl/cmp_timer.sv
// Compare timer top: register file, bus decode, flag logic and interrupt.
// Assumes a single clock domain; all sources arrive as tick enables.
// Reads are combinational; writes land at the clock edge.
module cmp_timer #(
    parameter int CNT_W       = 32,
    parameter int PRE_W       = 12,
    parameter int XPRE_W      = 4,
    parameter int NCMP        = 3,
    parameter int SRST_CYCLES = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_sel,
    input  logic        bus_wr,
    input  logic [2:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    input  logic [4:0]  src_ticks,
    input  logic        lowpwr,
    output logic        irq
);
    import cmp_timer_pkg::*;

    localparam int NST    = NCMP + 1;
    localparam int SRST_W = $clog2(SRST_CYCLES + 1);

    ctrl_t                     ctl;
    logic [PRE_W-1:0]          pre_main;
    logic [XPRE_W-1:0]         pre_x;
    logic [NST-1:0]            status;
    logic [NST-1:0]            ien;
    logic [NCMP-1:0][CNT_W-1:0] cmp_q;
    logic [SRST_W-1:0]         srst_cnt;

    logic                      srst_busy;
    logic                      wr;
    logic                      wr_ctrl;
    logic                      start_fresh;
    logic                      clr_all;
    logic                      active;
    logic                      tick_sel;
    logic                      step;
    logic [CNT_W-1:0]          count;
    logic [NCMP-1:0]           hit;
    logic                      wrap;
    logic [NST-1:0]            set_vec;
    logic [NST-1:0]            w1c;

    assign srst_busy   = (srst_cnt != '0);
    assign wr          = bus_sel & bus_wr & !srst_busy;
    assign wr_ctrl     = wr & (int'(bus_addr) == A_CTRL);
    assign start_fresh = wr_ctrl & !bus_wdata[SRST_BIT] & bus_wdata[0]
                         & bus_wdata[1] & !ctl.run;
    assign clr_all     = start_fresh | srst_busy;
    assign active      = ctl.run & !(lowpwr & !ctl.sleep_count);
    assign set_vec     = {wrap, hit};
    assign w1c         = (wr && int'(bus_addr) == A_STAT) ? bus_wdata[NST-1:0] : '0;
    assign irq         = |(status & ien);

    cmp_timer_src #(.XPRE_W(XPRE_W)) i_src (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (clr_all),
        .en        (active),
        .src       (ctl.src),
        .xdiv_en   (ctl.xdiv_en),
        .xratio_m1 (pre_x),
        .ticks     (src_ticks),
        .tick_sel  (tick_sel)
    );

    cmp_timer_div #(.W(PRE_W)) i_main_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (clr_all),
        .en       (active),
        .tick_in  (tick_sel),
        .ratio_m1 (pre_main),
        .tick_out (step)
    );

    cmp_timer_count #(.CNT_W(CNT_W), .NCMP(NCMP)) i_count (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (clr_all),
        .step     (step),
        .free_run (ctl.free_run),
        .cmp      (cmp_q),
        .count    (count),
        .hit      (hit),
        .wrap     (wrap)
    );

    // Software reset countdown: load on request, count down to idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            srst_cnt <= '0;
        end else if (srst_busy) begin
            srst_cnt <= srst_cnt - 1'b1;
        end else if (wr_ctrl && bus_wdata[SRST_BIT]) begin
            srst_cnt <= SRST_W'(SRST_CYCLES);
        end
    end

    // Control register; a software-reset write leaves the fields untouched.
    always_ff @(posedge clk) begin
        if (!rst_n || srst_busy) begin
            ctl <= '0;
        end else if (wr_ctrl && !bus_wdata[SRST_BIT]) begin
            ctl <= ctrl_t'(bus_wdata[7:0]);
        end
    end

    // Prescaler and interrupt-enable registers.
    always_ff @(posedge clk) begin
        if (!rst_n || srst_busy) begin
            pre_main <= '0;
            pre_x    <= '0;
            ien      <= '0;
        end else begin
            if (wr && int'(bus_addr) == A_PRE) begin
                pre_main <= bus_wdata[PRE_W-1:0];
                pre_x    <= bus_wdata[XPRE_LSB +: XPRE_W];
            end
            if (wr && int'(bus_addr) == A_IEN) begin
                ien <= bus_wdata[NST-1:0];
            end
        end
    end

    // Status flags: hardware set has priority over write-one-to-clear.
    always_ff @(posedge clk) begin
        if (!rst_n || srst_busy) begin
            status <= '0;
        end else begin
            status <= (status & ~w1c) | set_vec;
        end
    end

    // Compare value registers, one per channel.
    for (genvar i = 0; i < NCMP; i++) begin : g_cmp
        always_ff @(posedge clk) begin
            if (!rst_n || srst_busy) begin
                cmp_q[i] <= '0;
            end else if (wr && int'(bus_addr) == A_CMP0 + i) begin
                cmp_q[i] <= bus_wdata[CNT_W-1:0];
            end
        end

        // R7: a match pulse leaves its flag set in the next cycle.
        a_r7_hit_flag: assert property (@(posedge clk) disable iff (!rst_n)
            (hit[i] && !srst_busy) |=> status[i]);
    end

    // Read multiplexer.
    always_comb begin
        bus_rdata = '0;
        case (int'(bus_addr))
            A_CTRL: begin
                bus_rdata[7:0]      = ctl;
                bus_rdata[SRST_BIT] = srst_busy;
            end
            A_PRE: begin
                bus_rdata[PRE_W-1:0]            = pre_main;
                bus_rdata[XPRE_LSB +: XPRE_W]   = pre_x;
            end
            A_STAT:  bus_rdata[NST-1:0]   = status;
            A_IEN:   bus_rdata[NST-1:0]   = ien;
            A_CNT:   bus_rdata[CNT_W-1:0] = count;
            default: begin
                for (int i = 0; i < NCMP; i++) begin
                    if (int'(bus_addr) == A_CMP0 + i) bus_rdata[CNT_W-1:0] = cmp_q[i];
                end
            end
        endcase
    end

    // R5: a wrap pulse raises the rollover flag.
    a_r5_rov_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap && !srst_busy) |=> status[NCMP]);

    // R8: a clear of flag 0 with no coincident set leaves it low.
    a_r8_w1c: assert property (@(posedge clk) disable iff (!rst_n)
        (w1c[0] && !set_vec[0]) |=> !status[0]);

    // R10: while the software reset runs, state returns to defaults.
    a_r10_srst_defaults: assert property (@(posedge clk) disable iff (!rst_n)
        srst_busy |=> (status == '0 && !ctl.run && count == '0));

    // R11: a fresh start zeroes the count.
    a_r11_fresh_zero: assert property (@(posedge clk) disable iff (!rst_n)
        start_fresh |=> (count == '0));

endmodule

// File: tb/test_cmp_timer.sv
module test_cmp_timer;

    localparam int CNT_W = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [2:0]  bus_addr = 3'd0;
    logic [31:0] bus_wdata = 32'd0;
    logic [31:0] bus_rdata;
    logic        tick_all = 1'b0;
    logic        lowpwr = 1'b0;
    logic        irq;

    int n_chk = 0;
    int n_fail = 0;

    always #10 clk = ~clk;  // 50 MHz

    cmp_timer #(.CNT_W(CNT_W), .SRST_CYCLES(2)) i_cmp_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .src_ticks ({5{tick_all}}),
        .lowpwr    (lowpwr),
        .irq       (irq)
    );

    typedef struct packed {
        logic [2:0]  src;
        logic [11:0] m;
        logic [3:0]  x;
        logic        xen;
        logic [15:0] n;
        logic [31:0] expv;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{3'd1, 12'd0,    4'd0, 1'b0, 16'd10, 32'd10},  // R4 periph, R2 ratio 1
        '{3'd2, 12'd2,    4'd0, 1'b0, 16'd10, 32'd3},   // R2 ratio 3
        '{3'd3, 12'd4,    4'd0, 1'b0, 16'd20, 32'd4},   // R2 ratio 5
        '{3'd4, 12'd0,    4'd0, 1'b0, 16'd7,  32'd7},   // R4 slow ref
        '{3'd5, 12'd1,    4'd3, 1'b1, 16'd40, 32'd5},   // R3 cascade 4*2
        '{3'd5, 12'd1,    4'd3, 1'b0, 16'd40, 32'd20},  // R3 bypass
        '{3'd0, 12'd0,    4'd0, 1'b0, 16'd10, 32'd0},   // R4 none
        '{3'd6, 12'd0,    4'd0, 1'b0, 16'd10, 32'd0},   // R4 reserved
        '{3'd7, 12'd0,    4'd0, 1'b0, 16'd10, 32'd0},   // R4 reserved
        '{3'd1, 12'd4095, 4'd0, 1'b0, 16'd20, 32'd0}    // R2 ratio 4096
    };

    function automatic logic [31:0] ctrl_word(logic run, logic fresh, logic sleep,
                                              logic free, logic [2:0] src, logic xen);
        return {24'd0, xen, src, free, sleep, fresh, run};
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] expv);
        n_chk++;
        if (act !== expv) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, expv);
        end
    endtask

    task automatic bus_write(int addr, logic [31:0] data);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 3'(addr); bus_wdata = data;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_read(int addr, output logic [31:0] data);
        bus_addr = 3'(addr);
        #1;
        data = bus_rdata;
    endtask

    task automatic run_ticks(int n);
        @(negedge clk);
        tick_all = 1'b1;
        repeat (n) @(posedge clk);
        @(negedge clk);
        tick_all = 1'b0;
    endtask

    task automatic fresh_start(logic free, logic [2:0] src, logic xen);
        bus_write(0, ctrl_word(1'b0, 1'b0, 1'b0, free, src, xen));
        bus_write(0, ctrl_word(1'b1, 1'b1, 1'b0, free, src, xen));
    endtask

    initial begin
        logic [31:0] rd;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        for (int a = 0; a < 8; a++) begin
            bus_read(a, rd);
            chk("R1 reset register", rd, 32'd0);
        end
        chk("R1 irq low", {31'd0, irq}, 32'd0);

        // Vector walk: R2 R3 R4
        for (int v = 0; v < NV; v++) begin
            bus_write(1, {12'd0, VECS[v].x, 4'd0, VECS[v].m});
            fresh_start(1'b1, VECS[v].src, VECS[v].xen);
            run_ticks(int'(VECS[v].n));
            bus_read(4, rd);
            chk($sformatf("R2/R3/R4 vector %0d count", v), rd, VECS[v].expv);
        end

        // R7 compare flags, R9 interrupt
        bus_write(1, 32'd0);
        bus_write(3, 32'd0);
        bus_write(5, 32'd5);
        bus_write(6, 32'd7);
        bus_write(7, 32'd100);
        fresh_start(1'b1, 3'd1, 1'b0);
        bus_write(2, 32'h3F);
        run_ticks(8);
        bus_read(4, rd);
        chk("R7 count after 8", rd, 32'd8);
        bus_read(2, rd);
        chk("R7 flags ch1 ch2", rd, 32'h3);
        chk("R9 irq masked", {31'd0, irq}, 32'd0);
        bus_write(3, 32'h2);
        chk("R9 irq enabled", {31'd0, irq}, 32'd1);
        bus_write(2, 32'h1);
        bus_read(2, rd);
        chk("R8 single clear", rd, 32'h2);
        chk("R9 irq still on", {31'd0, irq}, 32'd1);
        bus_write(2, 32'h3F);
        bus_read(2, rd);
        chk("R8 clear all", rd, 32'h0);
        chk("R9 irq off", {31'd0, irq}, 32'd0);

        // R13 hold while stopped
        bus_write(0, ctrl_word(1'b0, 1'b0, 1'b0, 1'b1, 3'd1, 1'b0));
        run_ticks(5);
        bus_read(4, rd);
        chk("R13 held", rd, 32'd8);

        // R11 keep count without zero-on-start
        bus_write(0, ctrl_word(1'b1, 1'b0, 1'b0, 1'b1, 3'd1, 1'b0));
        run_ticks(3);
        bus_read(4, rd);
        chk("R11 count kept", rd, 32'd11);
        fresh_start(1'b1, 3'd1, 1'b0);
        bus_read(4, rd);
        chk("R11 zeroed on start", rd, 32'd0);

        // R12 low-power gating
        lowpwr = 1'b1;
        run_ticks(4);
        bus_read(4, rd);
        chk("R12 stalled", rd, 32'd0);
        bus_write(0, ctrl_word(1'b1, 1'b0, 1'b1, 1'b1, 3'd1, 1'b0));
        run_ticks(4);
        bus_read(4, rd);
        chk("R12 counts in low power", rd, 32'd4);
        lowpwr = 1'b0;

        // R6 restart mode
        bus_write(5, 32'd3);
        bus_write(2, 32'h3F);
        fresh_start(1'b0, 3'd1, 1'b0);
        run_ticks(10);
        bus_read(4, rd);
        chk("R6 restart count", rd, 32'd2);
        bus_read(2, rd);
        chk("R6 ch1 flag", rd, 32'h1);

        // R5 rollover
        bus_write(5, 32'd200);
        bus_write(6, 32'd200);
        bus_write(7, 32'd200);
        bus_write(2, 32'h3F);
        fresh_start(1'b1, 3'd1, 1'b0);
        run_ticks(260);
        bus_read(4, rd);
        chk("R5 wrapped count", rd, 32'd4);
        bus_read(2, rd);
        chk("R5 rollover and matches", rd, 32'hF);

        // R8 set wins over clear in the same cycle
        bus_write(5, 32'd3);
        bus_write(2, 32'h3F);
        fresh_start(1'b1, 3'd1, 1'b0);
        @(negedge clk);
        tick_all = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 3'd2; bus_wdata = 32'h1;
        @(posedge clk);
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0; tick_all = 1'b0;
        bus_read(4, rd);
        chk("R8 race count", rd, 32'd4);
        bus_read(2, rd);
        chk("R8 set wins", rd & 32'h1, 32'h1);

        // R10 software reset
        bus_write(3, 32'hF);
        bus_write(1, 32'h5);
        bus_write(0, 32'h8000);
        bus_read(0, rd);
        chk("R10 busy bit", rd & 32'h8000, 32'h8000);
        bus_write(3, 32'h0);
        bus_read(0, rd);
        chk("R10 self-cleared", rd, 32'd0);
        for (int a = 1; a < 8; a++) begin
            bus_read(a, rd);
            chk("R10 default", rd, 32'd0);
        end
        chk("R10 irq low", {31'd0, irq}, 32'd0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule